// File: doc/BRIEF.md
# Parallel LCD bus timing engine

This block sits on the host side of a slow parallel bus that goes to a character display controller. The bus is in 6800 style: register select, read/write, an enable strobe and an 8-bit data bus. A requester hands the block one transfer at a time. Each transfer carries the register-select value, the direction and, for writes, a data byte. The block places the control lines on the bus, raises and lowers the enable strobe, and drives or releases the data bus. It waits out the hold and recovery time, then reports that it is done. On reads it also returns the byte it captured.

Every bus time is a parameter in nanoseconds, together with the clock period. The block rounds each one up to whole clock cycles, with at least one cycle. A poll variant of the request keeps reading the controller's status byte until its top bit (the busy flag) reads 0. It then returns that final status byte with a single done.

Top module: `lcd_bus_engine`

## Requirements
- R1: While reset is asserted and right after it, the strobe is low, the data bus is released, the block is ready for a request and done is low.
- R2: Each time parameter becomes ceil(ns / CLK_NS) cycles, with a minimum of 1. With the defaults this gives a 1-cycle setup, a 35-cycle strobe, a 3-cycle hold and a 300-cycle strobe period.
- R3: Register select and read/write take the request's values at least the setup count of cycles before the strobe rises. They stay unchanged while the strobe is high and for at least the hold count of cycles after it falls.
- R4: The strobe stays high for exactly the largest of the pulse-width, read-delay and write-setup counts, which is 35 cycles by default.
- R5: Two strobe rises are never closer than the cycle-time count. Back-to-back rises within one poll are exactly that count apart.
- R6: When read/write is 0 (write), the data bus is driven with the request byte. The byte does not change while the strobe is high or during the hold count after the strobe falls.
- R7: When read/write is 1 (read), the data bus is released. The input byte is sampled on the last cycle in which the strobe is high, and it appears on rsp_rdata_o while rsp_valid_o is high.
- R8: The block accepts a request in a cycle where req_valid_i and req_ready_o are both high. req_ready_o stays low from acceptance until done. Done is a single-cycle pulse of rsp_valid_o, given once per request after the recovery time.
- R9: A poll request forces register select to 0 and read/write to 1. It repeats the status read while the captured bit 7 is 1. It gives exactly one done, with the first status byte whose bit 7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | A request is offered |
| req_ready_o | output | 1 | Block is idle and accepts a request |
| req_rs_i | input | 1 | Register select for the transfer |
| req_rnw_i | input | 1 | 1 = read, 0 = write |
| req_poll_i | input | 1 | Poll the status byte until the busy flag is clear |
| req_wdata_i | input | 8 | Write byte |
| rsp_valid_o | output | 1 | One-cycle done pulse |
| rsp_rdata_o | output | 8 | Captured read byte |
| lcd_rs_o | output | 1 | Register select to the display |
| lcd_rw_o | output | 1 | Read/write line to the display |
| lcd_e_o | output | 1 | Enable strobe |
| lcd_db_o | output | 8 | Data bus output value |
| lcd_db_oe_o | output | 1 | Data bus output enable |
| lcd_db_i | input | 8 | Data bus input value |

## Verification
The checker looks only at the bus-side outputs and the handshake. It assumes that the strobe-period parameter is at least as long as setup, strobe and hold combined, and that nothing is driven onto the data input except by the display side. The bench models the display: it returns garbage on the data input until the read-delay count has elapsed within a strobe, and again after the strobe falls. Each read therefore depends on the sample point. Random requests, including polls that see up to three busy reads, are issued only when the block is idle, so the bench always has exactly one transfer to score.

// File: rtl/lcd_bus_pkg.sv
package lcd_bus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_STROBE, ST_HOLD, ST_RECOVER
  } bus_state_e;

  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    if (c < 1) c = 1;
    return c;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/lcd_cycle_timer.sv
module lcd_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic         last_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= load_val_i;
    else if (cnt_q != '0)       cnt_q <= cnt_q - 1'b1;
  end

  assign last_o = (cnt_q == '0);
endmodule

// File: rtl/lcd_rd_capture.sv
module lcd_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/lcd_bus_engine.sv
module lcd_bus_engine
  import lcd_bus_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CLK_NS  = 4,
  parameter int AS_NS   = 0,
  parameter int PW_NS   = 140,
  parameter int CYC_NS  = 1200,
  parameter int AH_NS   = 10,
  parameter int DSW_NS  = 40,
  parameter int DH_NS   = 10,
  parameter int DDR_NS  = 100
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_rs_i,
  input  logic          req_rnw_i,
  input  logic          req_poll_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic          lcd_rs_o,
  output logic          lcd_rw_o,
  output logic          lcd_e_o,
  output logic [DW-1:0] lcd_db_o,
  output logic          lcd_db_oe_o,
  input  logic [DW-1:0] lcd_db_i
);
  localparam int AS_C   = ns_to_cyc(AS_NS, CLK_NS);
  localparam int HI_C   = max2(ns_to_cyc(PW_NS, CLK_NS),
                               max2(ns_to_cyc(DDR_NS, CLK_NS), ns_to_cyc(DSW_NS, CLK_NS)));
  localparam int HO_C   = max2(ns_to_cyc(AH_NS, CLK_NS), ns_to_cyc(DH_NS, CLK_NS));
  localparam int CYC_C  = ns_to_cyc(CYC_NS, CLK_NS);
  localparam int BODY_C = AS_C + HI_C + HO_C;
  // recovery pads the strobe period out to the cycle-time minimum
  localparam int REC_C  = (CYC_C > BODY_C) ? CYC_C - BODY_C : 1;
  localparam int MAX_C  = max2(max2(AS_C, HI_C), max2(HO_C, REC_C));
  localparam int CNT_W  = $clog2(MAX_C + 1);

  bus_state_e state_q, state_d;
  logic             tmr_load, tmr_last;
  logic [CNT_W-1:0] tmr_val;
  logic             rs_q, rw_q, poll_q, e_q, done_q, done_d, cap_en;
  logic [DW-1:0]    wdata_q, cap_q;
  logic             accept;

  assign accept = (state_q == ST_IDLE) && req_valid_i;

  lcd_cycle_timer #(.W(CNT_W)) i_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .last_o     (tmr_last)
  );

  lcd_rd_capture #(.DW(DW)) i_capture (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (cap_en),
    .d_i    (lcd_db_i),
    .q_o    (cap_q)
  );

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    cap_en   = 1'b0;
    done_d   = 1'b0;
    unique case (state_q)
      ST_IDLE: if (req_valid_i) begin
        state_d  = ST_SETUP;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(AS_C - 1);
      end
      ST_SETUP: if (tmr_last) begin
        state_d  = ST_STROBE;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HI_C - 1);
      end
      ST_STROBE: if (tmr_last) begin
        state_d  = ST_HOLD;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(HO_C - 1);
        cap_en   = rw_q;
      end
      ST_HOLD: if (tmr_last) begin
        state_d  = ST_RECOVER;
        tmr_load = 1'b1;
        tmr_val  = CNT_W'(REC_C - 1);
      end
      ST_RECOVER: if (tmr_last) begin
        if (poll_q && cap_q[DW-1]) begin
          state_d  = ST_SETUP;
          tmr_load = 1'b1;
          tmr_val  = CNT_W'(AS_C - 1);
        end else begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      e_q     <= 1'b0;
      done_q  <= 1'b0;
      rs_q    <= 1'b0;
      rw_q    <= 1'b1;
      poll_q  <= 1'b0;
      wdata_q <= '0;
    end else begin
      state_q <= state_d;
      e_q     <= (state_d == ST_STROBE);
      done_q  <= done_d;
      if (accept) begin
        rs_q    <= req_poll_i ? 1'b0 : req_rs_i;
        rw_q    <= req_poll_i ? 1'b1 : req_rnw_i;
        poll_q  <= req_poll_i;
        wdata_q <= req_wdata_i;
      end
    end
  end

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = done_q;
  assign rsp_rdata_o = cap_q;
  assign lcd_rs_o    = rs_q;
  assign lcd_rw_o    = rw_q;
  assign lcd_e_o     = e_q;
  assign lcd_db_o    = wdata_q;
  assign lcd_db_oe_o = ~rw_q;
endmodule

// File: rtl/lcd_bus_engine_chk.sv
module lcd_bus_engine_chk
  import lcd_bus_pkg::*;
#(
  parameter int DW      = 8,
  parameter int CLK_NS  = 4,
  parameter int AS_NS   = 0,
  parameter int PW_NS   = 140,
  parameter int CYC_NS  = 1200,
  parameter int AH_NS   = 10,
  parameter int DSW_NS  = 40,
  parameter int DH_NS   = 10,
  parameter int DDR_NS  = 100
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          lcd_e_o,
  input logic          lcd_rs_o,
  input logic          lcd_rw_o,
  input logic [DW-1:0] lcd_db_o,
  input logic          req_ready_o,
  input logic          rsp_valid_o
);
  localparam int HI_C  = max2(ns_to_cyc(PW_NS, CLK_NS),
                              max2(ns_to_cyc(DDR_NS, CLK_NS), ns_to_cyc(DSW_NS, CLK_NS)));
  localparam int HO_C  = max2(ns_to_cyc(AH_NS, CLK_NS), ns_to_cyc(DH_NS, CLK_NS));
  localparam int CYC_C = ns_to_cyc(CYC_NS, CLK_NS);
  localparam int AS_C  = ns_to_cyc(AS_NS, CLK_NS);

  logic [15:0] hi_cnt, rr_cnt, since_fall;
  logic        rise_seen, fall_seen, e_d, rs_d, rw_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cnt <= '0; rr_cnt <= '0; since_fall <= '0;
      rise_seen <= 1'b0; fall_seen <= 1'b0;
      e_d <= 1'b0; rs_d <= 1'b0; rw_d <= 1'b1;
    end else begin
      e_d  <= lcd_e_o;
      rs_d <= lcd_rs_o;
      rw_d <= lcd_rw_o;
      hi_cnt <= lcd_e_o ? hi_cnt + 16'd1 : 16'd0;
      if (lcd_e_o && !e_d) begin
        rr_cnt <= 16'd1; rise_seen <= 1'b1;
      end else if (rr_cnt != 16'hFFFF) rr_cnt <= rr_cnt + 16'd1;
      if (!lcd_e_o && e_d) begin
        since_fall <= 16'd1; fall_seen <= 1'b1;
      end else if (since_fall != 16'hFFFF) since_fall <= since_fall + 16'd1;
    end
  end

  assert_ctrl_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(lcd_e_o) |-> (AS_C >= 1) && $stable(lcd_rs_o) && $stable(lcd_rw_o));
  assert_ctrl_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fall_seen && !lcd_e_o && since_fall <= 16'(HO_C)) |-> (lcd_rs_o == rs_d && lcd_rw_o == rw_d));
  assert_ctrl_high_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o && e_d) |-> (lcd_rs_o == rs_d && lcd_rw_o == rw_d));
  assert_e_width_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(lcd_e_o) |-> hi_cnt == 16'(HI_C));
  assert_e_period_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(lcd_e_o) && rise_seen) |-> rr_cnt >= 16'(CYC_C));
  assert_wdata_stable_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lcd_e_o && e_d && !lcd_rw_o) |-> $stable(lcd_db_o));
  assert_one_in_flight_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lcd_e_o |-> !req_ready_o);
  assert_done_pulse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
endmodule

bind lcd_bus_engine lcd_bus_engine_chk #(
  .DW(DW), .CLK_NS(CLK_NS), .AS_NS(AS_NS), .PW_NS(PW_NS), .CYC_NS(CYC_NS),
  .AH_NS(AH_NS), .DSW_NS(DSW_NS), .DH_NS(DH_NS), .DDR_NS(DDR_NS)
) i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .lcd_e_o(lcd_e_o), .lcd_rs_o(lcd_rs_o),
  .lcd_rw_o(lcd_rw_o), .lcd_db_o(lcd_db_o), .req_ready_o(req_ready_o),
  .rsp_valid_o(rsp_valid_o)
);

// File: tb/test_lcd_bus_engine.sv
module test_lcd_bus_engine;
  // expected cycle counts for 4 ns clock and default ns values (R2)
  localparam int HI_C  = 35;
  localparam int HO_C  = 3;
  localparam int CYC_C = 300;
  localparam int DDR_C = 25;

  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       req_valid = 1'b0, req_rs = 1'b0, req_rnw = 1'b0, req_poll = 1'b0;
  logic [7:0] req_wdata = '0, lcd_db_i = '0;
  logic       req_ready, rsp_valid, lcd_rs, lcd_rw, lcd_e, lcd_db_oe;
  logic [7:0] rsp_rdata, lcd_db;

  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  lcd_bus_engine i_lcd_bus_engine (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(req_valid), .req_ready_o(req_ready),
    .req_rs_i(req_rs), .req_rnw_i(req_rnw), .req_poll_i(req_poll), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata), .lcd_rs_o(lcd_rs), .lcd_rw_o(lcd_rw),
    .lcd_e_o(lcd_e), .lcd_db_o(lcd_db), .lcd_db_oe_o(lcd_db_oe), .lcd_db_i(lcd_db_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // display model state
  logic       exp_rs = 1'b0, exp_rw = 1'b1;
  logic [7:0] dev_data = '0;
  logic [6:0] dev_ac = '0;
  int         busy = 0, pulses = 0;
  logic       wr_seen = 1'b0, wr_rs = 1'b0;
  logic [7:0] wr_data = '0;
  logic       e_prev = 1'b0, have_rise = 1'b0, snap_rs = 1'b0, snap_rw = 1'b0;
  logic [7:0] snap_db = '0;
  int         hi_run = 0, gap = 0, since_fall = 99, poll_active = 0;

  function automatic logic [7:0] dev_value(input logic rs);
    return rs ? dev_data : {busy > 0, dev_ac};
  endfunction

  always @(negedge clk) begin
    gap++;
    if (lcd_e && !e_prev) begin
      pulses++;
      chk(lcd_rs == exp_rs && lcd_rw == exp_rw, "R3 R9 ctrl at rise",
          {lcd_rs, lcd_rw}, {exp_rs, exp_rw});
      chk(lcd_db_oe == !lcd_rw, "R6 R7 bus drive", lcd_db_oe, !lcd_rw);
      chk(!req_ready, "R8 ready low in flight", req_ready, 0);
      if (have_rise) begin
        if (poll_active != 0 && pulses > 1)
          chk(gap == CYC_C, "R2 R5 poll period", gap, CYC_C);
        else
          chk(gap >= CYC_C, "R5 period", gap, CYC_C);
      end
      have_rise = 1'b1;
      gap = 0;
      hi_run = 0;
    end
    if (lcd_e) begin
      hi_run++;
      lcd_db_i <= (hi_run >= DDR_C) ? dev_value(lcd_rs) : 8'hA5;
    end else begin
      lcd_db_i <= 8'hA5;
      if (e_prev) begin
        chk(hi_run == HI_C, "R2 R4 strobe width", hi_run, HI_C);
        if (!lcd_rw) begin wr_seen = 1'b1; wr_rs = lcd_rs; wr_data = lcd_db; end
        else if (!lcd_rs && busy > 0) busy--;
        snap_rs = lcd_rs; snap_rw = lcd_rw; snap_db = lcd_db;
        since_fall = 0;
      end else begin
        since_fall++;
        if (since_fall == HO_C) begin
          chk(lcd_rs == snap_rs && lcd_rw == snap_rw, "R3 ctrl hold",
              {lcd_rs, lcd_rw}, {snap_rs, snap_rw});
          if (!snap_rw) chk(lcd_db == snap_db, "R6 data hold", lcd_db, snap_db);
        end
      end
    end
    e_prev = lcd_e;
  end

  task automatic xfer(input logic rs, input logic rnw, input logic poll,
                      input logic [7:0] wd, input int busy_init);
    logic [7:0] exp;
    int b0;
    @(negedge clk);
    dev_data = 8'($urandom);
    dev_ac   = 7'($urandom);
    busy     = busy_init;
    b0       = busy_init;
    pulses   = 0;
    wr_seen  = 1'b0;
    exp_rs   = poll ? 1'b0 : rs;
    exp_rw   = poll ? 1'b1 : rnw;
    poll_active = poll;
    req_valid = 1'b1; req_rs = rs; req_rnw = rnw; req_poll = poll; req_wdata = wd;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0; req_rs = ~rs; req_rnw = ~rnw; req_wdata = ~wd;
    while (!rsp_valid) @(negedge clk);
    if (poll) begin
      chk(pulses == b0 + 1, "R9 poll read count", pulses, b0 + 1);
      chk(rsp_rdata == {1'b0, dev_ac}, "R9 poll result", rsp_rdata, {1'b0, dev_ac});
    end else if (rnw) begin
      exp = rs ? dev_data : {b0 > 0, dev_ac};
      chk(rsp_rdata == exp, "R7 read data", rsp_rdata, exp);
      chk(pulses == 1, "R8 single strobe", pulses, 1);
    end else begin
      chk(wr_seen && wr_rs == rs && wr_data == wd, "R6 write seen",
          {wr_seen, wr_rs, wr_data}, {1'b1, rs, wd});
      chk(pulses == 1, "R8 single strobe", pulses, 1);
    end
    @(negedge clk);
    chk(!rsp_valid, "R8 done one cycle", rsp_valid, 0);
    chk(req_ready, "R8 ready after done", req_ready, 1);
    poll_active = 0;
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (5) @(negedge clk);
    chk(!lcd_e && !lcd_db_oe && req_ready && !rsp_valid, "R1 in reset",
        {lcd_e, lcd_db_oe, req_ready, rsp_valid}, 4'b0010);
    rst_ni = 1'b1;
    @(negedge clk);
    chk(!lcd_e && !lcd_db_oe && req_ready && !rsp_valid, "R1 after reset",
        {lcd_e, lcd_db_oe, req_ready, rsp_valid}, 4'b0010);
    // directed corners
    xfer(1'b0, 1'b0, 1'b0, 8'h38, 0);   // command write
    xfer(1'b1, 1'b0, 1'b0, 8'hFF, 0);   // data write
    xfer(1'b1, 1'b1, 1'b0, 8'h00, 0);   // data read
    xfer(1'b0, 1'b1, 1'b0, 8'h00, 2);   // status read while busy, no repeat
    xfer(1'b1, 1'b0, 1'b1, 8'h00, 0);   // poll, already idle
    xfer(1'b1, 1'b0, 1'b1, 8'h00, 3);   // poll through three busy reads
    // random mix
    for (int i = 0; i < 40; i++) begin
      logic p;
      p = ($urandom % 4) == 0;
      xfer(1'($urandom), 1'($urandom), p, 8'($urandom), int'($urandom % 4));
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R8 watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule